// File: doc/BRIEF.md
# CAN Fault Confinement Counters with Bus-Off Recovery

This block keeps the two fault-confinement counters of a CAN node, one for transmit and one for receive. It takes error and success events from the protocol engine and steps the counters by the usual CAN 2.0B amounts. It compares both counters with a programmable warning threshold and reports an error-status flag, an error-passive flag and a bus-off flag. When the error status or the bus state changes, it raises a single-cycle warning interrupt.

When a transmit error would push the transmit counter past its top value, the node goes bus-off. Both counters are reloaded, and the block asks the mode logic to set the reset-mode bit. The block waits until software has seen reset mode set and has then cleared it. After that it counts runs of eleven recessive sampled bits, stepping the transmit counter down once per run. The node returns to the bus after the 128th run. The same run detector also reports whether the bus line is idle.

Top module: `can_fault_confine`

## Requirements
- R1: After a synchronous active-low reset: both counters read 0, bus_off, err_status, err_passive, bus_idle, force_reset_mode and warn_irq read 0, and the warning threshold holds 96.
- R2: Outside bus-off, a transmit error adds 8 to tx_err_cnt and a receive error adds 1 to rx_err_cnt, saturating at 255. A success event subtracts 1 from its counter, never going below 0. If an error and a success hit the same counter in the same cycle, the error wins. Each change is visible on the cycle after the event.
- R3: A transmit error while tx_err_cnt is 248 or more enters bus-off. On the next cycle bus_off is 1, tx_err_cnt is 127, rx_err_cnt is 0 and force_reset_mode is 1.
- R4: force_reset_mode stays 1 until cpu_reset_mode is sampled 1. During bus-off, error and success events have no effect on the counters. The counters stay frozen until cpu_reset_mode has been seen 1 and then 0.
- R5: Once cpu_reset_mode has cleared, each run of 11 consecutive recessive samples decrements tx_err_cnt by 1. A sample is recessive when bit_tick=1 and bus_bit=1, and a dominant sample (bus_bit=0) restarts the run. On the 128th run, bus_off drops and both counters read 0.
- R6: err_status is 1 when bus_off is 1, or when either counter is greater than or equal to the threshold. The threshold loads from wl_wdata on a cycle with wl_we=1 and takes effect on the next cycle.
- R7: err_passive is 1 when bus_off is 0 and either counter is 128 or more.
- R8: bus_idle is 0 after reset until 11 consecutive recessive samples have been seen. It is then 1 until a dominant sample arrives.
- R9: With warn_irq_en=1, warn_irq is 1 for exactly the first cycle in which err_status or bus_off shows a new value. It is 0 while both levels are held, and it is 0 whenever warn_irq_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_tx_err | input | 1 | Transmit error detected this cycle |
| ev_tx_ok | input | 1 | Transmission succeeded this cycle |
| ev_rx_err | input | 1 | Receive error detected this cycle |
| ev_rx_ok | input | 1 | Reception succeeded this cycle |
| bit_tick | input | 1 | bus_bit holds a fresh sample |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive |
| cpu_reset_mode | input | 1 | Current reset-mode bit of the controller |
| wl_we | input | 1 | Load the warning threshold |
| wl_wdata | input | 8 | New warning threshold |
| warn_irq_en | input | 1 | Warning interrupt enable |
| tx_err_cnt | output | 8 | Transmit error counter |
| rx_err_cnt | output | 8 | Receive error counter |
| err_status | output | 1 | Counter at or above threshold, or bus-off |
| err_passive | output | 1 | Either counter at 128 or more |
| bus_off | output | 1 | Node is bus-off |
| bus_idle | output | 1 | Bus seen idle |
| force_reset_mode | output | 1 | Request to set the reset-mode bit |
| warn_irq | output | 1 | Warning interrupt pulse |

## Verification
A per-cycle reference model is checked against every output under a random event mix. In that mix the transmit errors outweigh the successes, so the node walks into bus-off and back many times. Sample gaps and rare dominant bits break the recessive runs, which separates correct run counting from counting single samples. Software is emulated by a mode bit that sets when reset mode is requested and clears after a random delay. Threshold rewrites and enable toggles change the warning interrupt between edges.

Directed cases cover the following:
- the default threshold, probed at 95 and 96 receive errors, where the interrupt fires once and not again while the level is held;
- the receive counter floor at 0;
- entry into bus-off from exactly 248, with events fired while frozen;
- a complete recovery that includes a dominant bit in the middle of a run.

// File: rtl/can_fc_pkg.sv
// Shared types for the fault-confinement block.
package can_fc_pkg;
    // Offline sequence: on the bus, waiting for reset mode to show set,
    // waiting for it to clear, counting idle runs back to the bus.
    typedef enum logic [1:0] {
        FC_ACTIVE      = 2'd0,
        FC_OFF_SET     = 2'd1,
        FC_OFF_CLR     = 2'd2,
        FC_OFF_RECOVER = 2'd3
    } fc_phase_e;
endpackage

// File: rtl/fc_idle_detect.sv
// Counts consecutive recessive samples. It emits seq_done on the sample
// that completes a run of IDLE_BITS and starts the next run from zero.
// bus_idle is held until a dominant sample arrives.
// Assumes bus_bit is only meaningful while bit_tick is 1.
module fc_idle_detect #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic bus_bit,
    input  logic restart,
    output logic seq_done,
    output logic bus_idle
);
    localparam int RUN_W = $clog2(IDLE_BITS + 1);
    localparam logic [RUN_W-1:0] LAST = RUN_W'(IDLE_BITS - 1);

    logic [RUN_W-1:0] run_q;
    logic             idle_q;

    assign seq_done = bit_tick & bus_bit & (run_q == LAST) & ~restart;
    assign bus_idle = idle_q;

    // Length of the current recessive run.
    always_ff @(posedge clk) begin
        if (!rst_n)                         run_q <= '0;
        else if (restart)                   run_q <= '0;
        else if (bit_tick) begin
            if (!bus_bit || run_q == LAST)  run_q <= '0;
            else                            run_q <= run_q + 1'b1;
        end
    end

    // Idle flag: set by a completed run, cleared by a dominant sample.
    always_ff @(posedge clk) begin
        if (!rst_n)                    idle_q <= 1'b0;
        else if (bit_tick && !bus_bit) idle_q <= 1'b0;
        else if (seq_done)             idle_q <= 1'b1;
    end

    a_r8_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !bus_bit) |=> !bus_idle);
    a_r8_idle_rise: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> bus_idle);
endmodule

// File: rtl/fc_counters.sv
// Transmit and receive error counters. Error events step the counters up
// and success events step them down to a floor of 0. tx_ovf flags a
// transmit error that would overflow the counter. The offline sequencer
// supplies load, decrement and clear. While hold is 1, all events are
// ignored.
module fc_counters #(
    parameter int CNT_W    = 8,
    parameter int TX_STEP  = 8,
    parameter int LOAD_VAL = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_tx_err,
    input  logic             ev_tx_ok,
    input  logic             ev_rx_err,
    input  logic             ev_rx_ok,
    input  logic             hold,
    input  logic             off_load,
    input  logic             rec_dec,
    input  logic             rec_clr,
    output logic [CNT_W-1:0] tx_cnt,
    output logic [CNT_W-1:0] rx_cnt,
    output logic             tx_ovf
);
    localparam logic [CNT_W:0]   STEP_EXT = (CNT_W+1)'(TX_STEP);
    localparam logic [CNT_W-1:0] LOAD     = CNT_W'(LOAD_VAL);

    logic [CNT_W:0] tx_sum;

    assign tx_sum = {1'b0, tx_cnt} + STEP_EXT;
    assign tx_ovf = ev_tx_err & tx_sum[CNT_W];

    // Transmit counter: bus-off load, recovery steps, normal events.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_cnt <= '0;
        else if (off_load) tx_cnt <= LOAD;
        else if (rec_clr)  tx_cnt <= '0;
        else if (rec_dec)  tx_cnt <= tx_cnt - 1'b1;
        else if (!hold) begin
            if (ev_tx_err)                  tx_cnt <= tx_sum[CNT_W-1:0];
            else if (ev_tx_ok && tx_cnt != 0) tx_cnt <= tx_cnt - 1'b1;
        end
    end

    // Receive counter: saturating count up, floor of 0 on count down.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rx_cnt <= '0;
        else if (off_load || rec_clr) rx_cnt <= '0;
        else if (!hold) begin
            if (ev_rx_err) begin
                if (rx_cnt != '1)     rx_cnt <= rx_cnt + 1'b1;
            end
            else if (ev_rx_ok && rx_cnt != 0) rx_cnt <= rx_cnt - 1'b1;
        end
    end

    a_r2_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && ev_tx_err && !tx_ovf) |=> tx_cnt == $past(tx_cnt) + CNT_W'(TX_STEP));
    a_r2_rx_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !ev_rx_err && ev_rx_ok && rx_cnt == 0) |=> rx_cnt == 0);
endmodule

// File: rtl/fc_offline_fsm.sv
// Sequences bus-off. An overflow enters FC_OFF_SET, where the block
// requests reset mode. Seeing reset mode set moves to FC_OFF_CLR. Its
// clearing moves to FC_OFF_RECOVER, which steps the transmit counter once
// per idle run. The run that finds the counter at zero returns to the bus.
module fc_offline_fsm
    import can_fc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tx_ovf,
    input  logic      cpu_reset_mode,
    input  logic      seq_done,
    input  logic      tx_zero,
    output fc_phase_e phase,
    output logic      off_load,
    output logic      rec_dec,
    output logic      rec_clr,
    output logic      restart
);
    fc_phase_e phase_d;

    assign off_load = (phase == FC_ACTIVE)      & tx_ovf;
    assign restart  = (phase == FC_OFF_CLR)     & ~cpu_reset_mode;
    assign rec_dec  = (phase == FC_OFF_RECOVER) & seq_done & ~tx_zero;
    assign rec_clr  = (phase == FC_OFF_RECOVER) & seq_done & tx_zero;

    // Next-phase selection.
    always_comb begin
        phase_d = phase;
        unique case (phase)
            FC_ACTIVE:      if (off_load)       phase_d = FC_OFF_SET;
            FC_OFF_SET:     if (cpu_reset_mode) phase_d = FC_OFF_CLR;
            FC_OFF_CLR:     if (restart)        phase_d = FC_OFF_RECOVER;
            FC_OFF_RECOVER: if (rec_clr)        phase_d = FC_ACTIVE;
            default:                            phase_d = FC_ACTIVE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= FC_ACTIVE;
        else        phase <= phase_d;
    end

    a_r4_wait_set: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == FC_OFF_SET && !cpu_reset_mode) |=> phase == FC_OFF_SET);
    a_r5_return: assert property (@(posedge clk) disable iff (!rst_n)
        rec_clr |=> phase == FC_ACTIVE);
endmodule

// File: rtl/can_fault_confine.sv
// Top of the fault-confinement block. It holds the warning threshold
// register and derives the status flags and the warning interrupt.
// Assumes the event inputs are single-cycle pulses from the protocol
// engine.
module can_fault_confine
    import can_fc_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int TX_STEP      = 8,
    parameter int IDLE_BITS    = 11,
    parameter int RECOVER_SEQS = 128,
    parameter int WARN_RESET   = 96,
    parameter int PASSIVE_LIM  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_tx_err,
    input  logic             ev_tx_ok,
    input  logic             ev_rx_err,
    input  logic             ev_rx_ok,
    input  logic             bit_tick,
    input  logic             bus_bit,
    input  logic             cpu_reset_mode,
    input  logic             wl_we,
    input  logic [CNT_W-1:0] wl_wdata,
    input  logic             warn_irq_en,
    output logic [CNT_W-1:0] tx_err_cnt,
    output logic [CNT_W-1:0] rx_err_cnt,
    output logic             err_status,
    output logic             err_passive,
    output logic             bus_off,
    output logic             bus_idle,
    output logic             force_reset_mode,
    output logic             warn_irq
);
    localparam int               LOAD_VAL = RECOVER_SEQS - 1;
    localparam logic [CNT_W-1:0] PASSIVE  = CNT_W'(PASSIVE_LIM);
    localparam logic [CNT_W-1:0] WL_INIT  = CNT_W'(WARN_RESET);

    fc_phase_e        phase;
    logic             off_load, rec_dec, rec_clr, restart;
    logic             seq_done, tx_ovf;
    logic [CNT_W-1:0] warn_lim;
    logic             es_q, bo_q;

    fc_idle_detect #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bus_bit(bus_bit),
        .restart(restart), .seq_done(seq_done), .bus_idle(bus_idle)
    );

    fc_counters #(.CNT_W(CNT_W), .TX_STEP(TX_STEP), .LOAD_VAL(LOAD_VAL)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .ev_tx_err(ev_tx_err), .ev_tx_ok(ev_tx_ok),
        .ev_rx_err(ev_rx_err), .ev_rx_ok(ev_rx_ok),
        .hold(bus_off), .off_load(off_load), .rec_dec(rec_dec), .rec_clr(rec_clr),
        .tx_cnt(tx_err_cnt), .rx_cnt(rx_err_cnt), .tx_ovf(tx_ovf)
    );

    fc_offline_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tx_ovf(tx_ovf), .cpu_reset_mode(cpu_reset_mode),
        .seq_done(seq_done), .tx_zero(tx_err_cnt == '0), .phase(phase),
        .off_load(off_load), .rec_dec(rec_dec), .rec_clr(rec_clr), .restart(restart)
    );

    assign bus_off          = (phase != FC_ACTIVE);
    assign force_reset_mode = (phase == FC_OFF_SET);
    assign err_status       = bus_off | (tx_err_cnt >= warn_lim) | (rx_err_cnt >= warn_lim);
    assign err_passive      = ~bus_off & ((tx_err_cnt >= PASSIVE) | (rx_err_cnt >= PASSIVE));
    assign warn_irq         = warn_irq_en & ((err_status ^ es_q) | (bus_off ^ bo_q));

    // Warning threshold register.
    always_ff @(posedge clk) begin
        if (!rst_n)     warn_lim <= WL_INIT;
        else if (wl_we) warn_lim <= wl_wdata;
    end

    // Previous status levels, used for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            es_q <= 1'b0;
            bo_q <= 1'b0;
        end else begin
            es_q <= err_status;
            bo_q <= bus_off;
        end
    end

    a_r3_busoff_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_off) |-> (tx_err_cnt == CNT_W'(LOAD_VAL) && rx_err_cnt == 0));
    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == FC_OFF_SET || phase == FC_OFF_CLR) |=>
            ($stable(tx_err_cnt) && $stable(rx_err_cnt)));
    a_r5_exit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_off) |-> (tx_err_cnt == 0 && rx_err_cnt == 0 && !err_status));
endmodule

// File: tb/can_fault_confine_test.sv
module can_fault_confine_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_tx_err = 0, ev_tx_ok = 0, ev_rx_err = 0, ev_rx_ok = 0;
    logic bit_tick = 0, bus_bit = 1, cpu_reset_mode = 0;
    logic wl_we = 0, warn_irq_en = 0;
    logic [7:0] wl_wdata = 0;
    logic [7:0] tx_err_cnt, rx_err_cnt;
    logic err_status, err_passive, bus_off, bus_idle, force_reset_mode, warn_irq;

    int checks = 0, errors = 0;
    bit done = 0;
    // Reference model state.
    int m_tx, m_rx, m_ph, m_run, m_lim;
    bit m_idle, m_esq, m_boq;

    can_fault_confine uut (
        .clk(clk), .rst_n(rst_n), .ev_tx_err(ev_tx_err), .ev_tx_ok(ev_tx_ok),
        .ev_rx_err(ev_rx_err), .ev_rx_ok(ev_rx_ok), .bit_tick(bit_tick),
        .bus_bit(bus_bit), .cpu_reset_mode(cpu_reset_mode), .wl_we(wl_we),
        .wl_wdata(wl_wdata), .warn_irq_en(warn_irq_en), .tx_err_cnt(tx_err_cnt),
        .rx_err_cnt(rx_err_cnt), .err_status(err_status), .err_passive(err_passive),
        .bus_off(bus_off), .bus_idle(bus_idle), .force_reset_mode(force_reset_mode),
        .warn_irq(warn_irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_es(int tx, int rx, int ph, int lim);
        return (ph != 0) || tx >= lim || rx >= lim;
    endfunction

    task automatic check_all();
        bit bo, es, ep, irq;
        bo  = (m_ph != 0);
        es  = exp_es(m_tx, m_rx, m_ph, m_lim);
        ep  = !bo && (m_tx >= 128 || m_rx >= 128);
        irq = warn_irq_en && ((es != m_esq) || (bo != m_boq));
        chk(m_ph != 0 ? "R5 tx_err_cnt" : "R2 tx_err_cnt", int'(tx_err_cnt), m_tx);
        chk(m_ph != 0 ? "R4 rx_err_cnt" : "R2 rx_err_cnt", int'(rx_err_cnt), m_rx);
        chk("R3 bus_off", int'(bus_off), int'(bo));
        chk("R4 force_reset_mode", int'(force_reset_mode), int'(m_ph == 1));
        chk("R6 err_status", int'(err_status), int'(es));
        chk("R7 err_passive", int'(err_passive), int'(ep));
        chk("R8 bus_idle", int'(bus_idle), int'(m_idle));
        chk("R9 warn_irq", int'(warn_irq), int'(irq));
    endtask

    // One clock: predict from current inputs and state, then compare.
    task automatic step();
        int n_tx, n_rx, n_ph, n_run;
        bit restart, seq, bo, es, n_idle;
        bo = (m_ph != 0);
        es = exp_es(m_tx, m_rx, m_ph, m_lim);
        restart = (m_ph == 2) && !cpu_reset_mode;
        seq = bit_tick && bus_bit && m_run == 10 && !restart;
        n_run = restart ? 0 : (bit_tick ? ((bus_bit && m_run != 10) ? m_run + 1 : 0) : m_run);
        n_idle = (bit_tick && !bus_bit) ? 1'b0 : (seq ? 1'b1 : m_idle);
        n_tx = m_tx; n_rx = m_rx; n_ph = m_ph;
        case (m_ph)
            0: begin
                if (ev_tx_err && m_tx + 8 > 255) begin
                    n_tx = 127; n_rx = 0; n_ph = 1;
                end else begin
                    if (ev_tx_err) n_tx = m_tx + 8;
                    else if (ev_tx_ok && m_tx > 0) n_tx = m_tx - 1;
                    if (ev_rx_err) n_rx = (m_rx < 255) ? m_rx + 1 : 255;
                    else if (ev_rx_ok && m_rx > 0) n_rx = m_rx - 1;
                end
            end
            1: if (cpu_reset_mode) n_ph = 2;
            2: if (!cpu_reset_mode) n_ph = 3;
            default: if (seq) begin
                if (m_tx == 0) begin n_rx = 0; n_ph = 0; end
                else n_tx = m_tx - 1;
            end
        endcase
        if (wl_we) m_lim = int'(wl_wdata);
        @(posedge clk); #1;
        m_esq = es; m_boq = bo;
        m_tx = n_tx; m_rx = n_rx; m_ph = n_ph; m_run = n_run; m_idle = n_idle;
        check_all();
    endtask

    task automatic quiet();
        ev_tx_err = 0; ev_tx_ok = 0; ev_rx_err = 0; ev_rx_ok = 0; wl_we = 0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        m_tx = 0; m_rx = 0; m_ph = 0; m_run = 0; m_lim = 96; m_idle = 0; m_esq = 0; m_boq = 0;
        // R1: reset state.
        chk("R1 tx_err_cnt", int'(tx_err_cnt), 0);
        chk("R1 rx_err_cnt", int'(rx_err_cnt), 0);
        chk("R1 bus_off", int'(bus_off), 0);
        chk("R1 err_status", int'(err_status), 0);
        chk("R1 bus_idle", int'(bus_idle), 0);
        chk("R1 force_reset_mode", int'(force_reset_mode), 0);
        chk("R1 warn_irq", int'(warn_irq), 0);

        // R1/R6: default threshold of 96 probed with receive errors.
        warn_irq_en = 1;
        ev_rx_err = 1;
        repeat (95) step();
        chk("R6 threshold 95 below default", int'(err_status), 0);
        step();
        chk("R1 default threshold 96 reached", int'(err_status), 1);
        chk("R9 irq on rise", int'(warn_irq), 1);
        quiet(); step();
        chk("R9 no irq while held", int'(warn_irq), 0);
        // R2: count down to the floor and past it.
        ev_rx_ok = 1;
        repeat (100) step();
        chk("R2 rx floor", int'(rx_err_cnt), 0);

        // R3: reach 248 then overflow.
        quiet(); ev_tx_err = 1;
        repeat (31) step();
        chk("R2 tx at 248", int'(tx_err_cnt), 248);
        step();
        chk("R3 bus_off entry", int'(bus_off), 1);
        chk("R3 tx loaded", int'(tx_err_cnt), 127);
        // R4: events ignored while waiting for software.
        ev_rx_err = 1; ev_tx_ok = 1;
        repeat (5) step();
        chk("R4 frozen tx", int'(tx_err_cnt), 127);
        quiet(); cpu_reset_mode = 1;
        repeat (3) step();
        chk("R4 request dropped", int'(force_reset_mode), 0);
        cpu_reset_mode = 0;
        // R5: full recovery with a dominant bit inside a run.
        bit_tick = 1; bus_bit = 1;
        repeat (30) step();
        bus_bit = 0; step(); bus_bit = 1;
        for (int i = 0; i < 2000 && m_ph != 0; i++) step();
        chk("R5 back on bus", int'(bus_off), 0);
        chk("R5 tx cleared", int'(tx_err_cnt), 0);

        // Random mix.
        for (int i = 0; i < 60000; i++) begin
            ev_tx_err = ($urandom % 16) < 3;
            ev_tx_ok  = ($urandom % 4) == 0;
            ev_rx_err = ($urandom % 5) == 0;
            ev_rx_ok  = ($urandom % 4) == 0;
            bit_tick  = $urandom % 2;
            bus_bit   = ($urandom % 40) != 0;
            wl_we     = ($urandom % 500) == 0;
            wl_wdata  = 8'($urandom % 256);
            if (($urandom % 4000) == 0) warn_irq_en = !warn_irq_en;
            if (force_reset_mode) cpu_reset_mode = 1;
            else if (cpu_reset_mode && ($urandom % 30) == 0) cpu_reset_mode = 0;
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule